// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache

This block sits between a processor byte port and a slower memory that moves whole lines. Every byte address is split into tag, set index and byte offset. Both ways of the selected set are compared in parallel. A line can live in either way of the one set its index names. Stores that hit only change the cached copy and mark the line dirty. Every miss, load or store, first fetches the whole line from memory (write-allocate) and then completes as a hit. The victim within the set is the least recently used way.

A dirty victim is copied into a small first-in first-out eviction queue. That queue drains to memory on its own, so the refill read is issued without waiting for the writeback to be confirmed. A miss to a line that is still waiting in the queue is held until that entry has been confirmed. This keeps a refill from reading stale memory. A dirty eviction that finds the queue full is also held until an entry drains.

The processor request, the memory read request and the writeback request each use a valid/ready pair. A sender holds valid and its payload steady until ready is seen at a clock edge. `req_ready` low is the processor stall. The processor response and the memory read response are single-cycle pulses with no back-pressure. At most one refill read is outstanding, and the cache always takes its response. The memory confirms each accepted writeback with a one-cycle `wb_done` pulse. The cache removes the queue head on that pulse.

Top module: `wb_cache2w`

## Requirements
- R1: After reset every line is invalid and the eviction queue is empty, `req_ready` is 1, and `resp_valid`, `rd_req_valid` and `wb_valid` are 0.
- R2: Address bit 0 is the byte offset, bits 2:1 the set index and bits 4:3 the tag. The memory line address is address bits 4:1. The byte at offset k sits in bits 8k+7:8k of a line.
- R3: A load returns the byte most recently stored to its address, or the initial memory content if it was never stored.
- R4: On a hit, `resp_valid` is high for exactly the one cycle between the first and second rising edges after the accepting edge. A hit makes no memory request.
- R5: A load or store miss issues exactly one refill read, for the requested line address. The filled line is valid and clean.
- R6: A store hit writes only the cached line and marks it dirty. No memory write happens at that time.
- R7: Evicting a clean line produces no writeback. Evicting a dirty line queues exactly one writeback carrying its line address and full data.
- R8: Each set keeps one recency bit. Every hit or fill in a set points that bit at the other way, and a miss replaces the way it points at.
- R9: The refill for a miss is issued and completes while the dirty victim's writeback is still unconfirmed.
- R10: Writebacks leave in eviction order, one at a time. The next one is not offered until the previous one is confirmed by `wb_done`.
- R11: A dirty eviction with a full queue holds the request, with `req_ready` low and no refill read, until an entry drains.
- R12: A miss whose line is still in the eviction queue issues no refill read until that entry is confirmed.
- R13: `req_ready` is low from acceptance until the response. A pending memory read or writeback request keeps valid and payload stable until ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Cache can take a request; low means stall |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 5 | Byte address |
| req_wdata | input | 8 | Store byte |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | 8 | Loaded byte (stores echo the written byte) |
| rd_req_valid | output | 1 | Refill read request |
| rd_req_ready | input | 1 | Memory accepts the refill read |
| rd_req_line | output | 4 | Line address to read |
| rd_resp_valid | input | 1 | Refill data pulse |
| rd_resp_data | input | 16 | Refill line data |
| wb_valid | output | 1 | Writeback offered from the queue head |
| wb_ready | input | 1 | Memory accepts the writeback |
| wb_line | output | 4 | Line address of the writeback |
| wb_data | output | 16 | Line data of the writeback |
| wb_done | input | 1 | Memory confirms the accepted writeback |

## Verification
A hit response is due on the second falling edge after the accepting rising edge. The bench counts falling edges from acceptance and requires exactly two for hits and more than two for misses. Miss and stall results have no fixed latency because they depend on the memory's ready and response timing. For those, the bench holds the writeback port closed, samples at every falling edge over a fixed window that no refill or response may cross, and then opens the port and waits for the response. Writeback contents and order are taken from a log filled at each confirmation and are checked only after the queue has had time to drain.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  localparam int WAYS = 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_FILL_REQ,
    ST_FILL_WAIT
  } wbc_state_e;
endpackage

// File: rtl/wbc_ways.sv
// Tag, state and data storage for both ways, with parallel tag compare.
module wbc_ways
  import wbc_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 2,
  parameter int LINE_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [IDX_W-1:0]              lk_idx,
  input  logic [TAG_W-1:0]              lk_tag,
  output logic [WAYS-1:0]               way_hit,
  output logic [WAYS-1:0]               way_valid,
  output logic [WAYS-1:0]               way_dirty,
  output logic [WAYS-1:0][TAG_W-1:0]    way_tag,
  output logic [WAYS-1:0][LINE_W-1:0]   way_data,
  input  logic                          wr_en,
  input  logic                          wr_way,
  input  logic [IDX_W-1:0]              wr_idx,
  input  logic                          wr_valid,
  input  logic                          wr_dirty,
  input  logic [TAG_W-1:0]              wr_tag,
  input  logic [LINE_W-1:0]             wr_data
);
  localparam int SETS = 1 << IDX_W;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [SETS-1:0]   v_q;
    logic [SETS-1:0]   d_q;
    logic [TAG_W-1:0]  tag_q [SETS];
    logic [LINE_W-1:0] dat_q [SETS];
    logic              sel;

    assign sel = wr_en && (wr_way == 1'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= '0;
        d_q <= '0;
      end else if (sel) begin
        v_q[wr_idx] <= wr_valid;
        d_q[wr_idx] <= wr_dirty;
      end
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        tag_q[wr_idx] <= wr_tag;
        dat_q[wr_idx] <= wr_data;
      end
    end

    assign way_valid[w] = v_q[lk_idx];
    assign way_dirty[w] = d_q[lk_idx];
    assign way_tag[w]   = tag_q[lk_idx];
    assign way_data[w]  = dat_q[lk_idx];
    assign way_hit[w]   = v_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  end
endmodule

// File: rtl/wbc_lru.sv
// One recency bit per set; the bit names the way to replace next.
module wbc_lru #(
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  output logic             victim,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  input  logic             touch_way
);
  localparam int SETS = 1 << IDX_W;

  logic [SETS-1:0] rec_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_q <= '0;
    end else if (touch_en) begin
      rec_q[touch_idx] <= ~touch_way;
    end
  end

  assign victim = rec_q[lk_idx];
endmodule

// File: rtl/wbc_wbq.sv
// FIFO of dirty victims draining to memory, with a line-address probe.
module wbc_wbq #(
  parameter int DEPTH  = 2,
  parameter int LA_W   = 4,
  parameter int LINE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_en,
  input  logic [LA_W-1:0]   push_line,
  input  logic [LINE_W-1:0] push_data,
  output logic              full,
  input  logic [LA_W-1:0]   probe_line,
  output logic              probe_hit,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [LA_W-1:0]   wb_line,
  output logic [LINE_W-1:0] wb_data,
  input  logic              wb_done
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0]  vld_q;
  logic [LA_W-1:0]   ln_q [DEPTH];
  logic [LINE_W-1:0] dt_q [DEPTH];
  logic [PTR_W-1:0]  wp_q;
  logic [PTR_W-1:0]  rp_q;
  logic              sent_q;
  logic              pop;
  logic [DEPTH-1:0]  match;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    if (int'(p) == DEPTH - 1) return '0;
    return p + 1'b1;
  endfunction

  assign pop = wb_done && sent_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      wp_q   <= '0;
      rp_q   <= '0;
      sent_q <= 1'b0;
    end else begin
      if (push_en) begin
        vld_q[wp_q] <= 1'b1;
        wp_q        <= bump(wp_q);
      end
      if (pop) begin
        vld_q[rp_q] <= 1'b0;
        rp_q        <= bump(rp_q);
        sent_q      <= 1'b0;
      end else if (wb_valid && wb_ready) begin
        sent_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push_en) begin
      ln_q[wp_q] <= push_line;
      dt_q[wp_q] <= push_data;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_probe
    assign match[i] = vld_q[i] && (ln_q[i] == probe_line);
  end

  assign probe_hit = |match;
  assign full      = &vld_q;
  assign wb_valid  = vld_q[rp_q] && !sent_q;
  assign wb_line   = ln_q[rp_q];
  assign wb_data   = dt_q[rp_q];
endmodule

// File: rtl/wb_cache2w.sv
module wb_cache2w
  import wbc_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int IDX_W     = 2,
  parameter int OFF_W     = 1,
  parameter int BYTE_W    = 8,
  parameter int WBQ_DEPTH = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           req_valid,
  output logic                           req_ready,
  input  logic                           req_write,
  input  logic [ADDR_W-1:0]              req_addr,
  input  logic [BYTE_W-1:0]              req_wdata,
  output logic                           resp_valid,
  output logic [BYTE_W-1:0]              resp_rdata,
  output logic                           rd_req_valid,
  input  logic                           rd_req_ready,
  output logic [ADDR_W-OFF_W-1:0]        rd_req_line,
  input  logic                           rd_resp_valid,
  input  logic [BYTE_W*(2**OFF_W)-1:0]   rd_resp_data,
  output logic                           wb_valid,
  input  logic                           wb_ready,
  output logic [ADDR_W-OFF_W-1:0]        wb_line,
  output logic [BYTE_W*(2**OFF_W)-1:0]   wb_data,
  input  logic                           wb_done
);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int LA_W   = ADDR_W - OFF_W;
  localparam int LINE_W = BYTE_W * (2 ** OFF_W);

  // request registers
  wbc_state_e          state_q;
  logic                r_write;
  logic [ADDR_W-1:0]   r_addr;
  logic [BYTE_W-1:0]   r_wdata;
  logic                resp_valid_q;
  logic [BYTE_W-1:0]   resp_rdata_q;
  logic                fill_way_q;

  // address fields (R2)
  logic [OFF_W-1:0]    r_off;
  logic [IDX_W-1:0]    r_idx;
  logic [TAG_W-1:0]    r_tag;
  logic [LA_W-1:0]     r_line;

  assign r_off  = r_addr[OFF_W-1:0];
  assign r_idx  = r_addr[OFF_W +: IDX_W];
  assign r_tag  = r_addr[ADDR_W-1 -: TAG_W];
  assign r_line = r_addr[ADDR_W-1:OFF_W];

  // storage outputs
  logic [WAYS-1:0]             way_hit;
  logic [WAYS-1:0]             way_valid;
  logic [WAYS-1:0]             way_dirty;
  logic [WAYS-1:0][TAG_W-1:0]  way_tag;
  logic [WAYS-1:0][LINE_W-1:0] way_data;

  // storage write port
  logic                arr_we;
  logic                arr_way;
  logic                arr_v;
  logic                arr_d;
  logic [TAG_W-1:0]    arr_tag;
  logic [LINE_W-1:0]   arr_data;

  // lookup results
  logic                hit;
  logic                hit_way;
  logic [LINE_W-1:0]   hit_line;
  logic [BYTE_W-1:0]   hit_byte;
  logic [LINE_W-1:0]   merged;
  logic                victim;
  logic                vic_valid;
  logic                vic_dirty;
  logic                do_hit;
  logic                do_miss;
  logic                evict_ok;
  logic                fill_now;

  // queue handshake
  logic                q_push;
  logic                q_full;
  logic                q_probe_hit;
  logic                lru_touch;
  logic                lru_way;

  wbc_ways #(
    .IDX_W (IDX_W),
    .TAG_W (TAG_W),
    .LINE_W(LINE_W)
  ) u_ways (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_idx   (r_idx),
    .lk_tag   (r_tag),
    .way_hit  (way_hit),
    .way_valid(way_valid),
    .way_dirty(way_dirty),
    .way_tag  (way_tag),
    .way_data (way_data),
    .wr_en    (arr_we),
    .wr_way   (arr_way),
    .wr_idx   (r_idx),
    .wr_valid (arr_v),
    .wr_dirty (arr_d),
    .wr_tag   (arr_tag),
    .wr_data  (arr_data)
  );

  wbc_lru #(
    .IDX_W(IDX_W)
  ) u_lru (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_idx   (r_idx),
    .victim   (victim),
    .touch_en (lru_touch),
    .touch_idx(r_idx),
    .touch_way(lru_way)
  );

  wbc_wbq #(
    .DEPTH (WBQ_DEPTH),
    .LA_W  (LA_W),
    .LINE_W(LINE_W)
  ) u_wbq (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_en   (q_push),
    .push_line ({way_tag[victim], r_idx}),
    .push_data (way_data[victim]),
    .full      (q_full),
    .probe_line(r_line),
    .probe_hit (q_probe_hit),
    .wb_valid  (wb_valid),
    .wb_ready  (wb_ready),
    .wb_line   (wb_line),
    .wb_data   (wb_data),
    .wb_done   (wb_done)
  );

  // hit data path
  assign hit      = |way_hit;
  assign hit_way  = way_hit[1];
  assign hit_line = way_data[hit_way];
  assign hit_byte = hit_line[int'(r_off)*BYTE_W +: BYTE_W];

  always_comb begin
    merged = hit_line;
    merged[int'(r_off)*BYTE_W +: BYTE_W] = r_wdata;
  end

  // miss handling decisions
  assign vic_valid = way_valid[victim];
  assign vic_dirty = vic_valid && way_dirty[victim];
  assign do_hit    = (state_q == ST_LOOKUP) && hit;
  assign do_miss   = (state_q == ST_LOOKUP) && !hit;
  // hold while the wanted line is queued (R12) or the queue cannot take a victim (R11)
  assign evict_ok  = do_miss && !q_probe_hit && !(vic_dirty && q_full);
  assign q_push    = evict_ok && vic_dirty;
  assign fill_now  = (state_q == ST_FILL_WAIT) && rd_resp_valid;

  // single write port: store hit, eviction, or refill
  always_comb begin
    arr_we   = 1'b0;
    arr_way  = hit_way;
    arr_v    = 1'b1;
    arr_d    = 1'b0;
    arr_tag  = r_tag;
    arr_data = rd_resp_data;
    if (do_hit && r_write) begin
      arr_we   = 1'b1;
      arr_d    = 1'b1;
      arr_data = merged;
    end else if (evict_ok && vic_valid) begin
      arr_we   = 1'b1;
      arr_way  = victim;
      arr_v    = 1'b0;
      arr_tag  = way_tag[victim];
      arr_data = way_data[victim];
    end else if (fill_now) begin
      arr_we   = 1'b1;
      arr_way  = fill_way_q;
    end
  end

  assign lru_touch = do_hit || fill_now;
  assign lru_way   = fill_now ? fill_way_q : hit_way;

  // control sequence
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      r_write      <= 1'b0;
      r_addr       <= '0;
      r_wdata      <= '0;
      resp_valid_q <= 1'b0;
      resp_rdata_q <= '0;
      fill_way_q   <= 1'b0;
    end else begin
      resp_valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            r_write <= req_write;
            r_addr  <= req_addr;
            r_wdata <= req_wdata;
            state_q <= ST_LOOKUP;
          end
        end
        ST_LOOKUP: begin
          if (hit) begin
            resp_valid_q <= 1'b1;
            resp_rdata_q <= r_write ? r_wdata : hit_byte;
            state_q      <= ST_IDLE;
          end else if (evict_ok) begin
            fill_way_q <= victim;
            state_q    <= ST_FILL_REQ;
          end
        end
        ST_FILL_REQ: begin
          if (rd_req_ready) state_q <= ST_FILL_WAIT;
        end
        ST_FILL_WAIT: begin
          if (rd_resp_valid) state_q <= ST_LOOKUP;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready    = (state_q == ST_IDLE);
  assign resp_valid   = resp_valid_q;
  assign resp_rdata   = resp_rdata_q;
  assign rd_req_valid = (state_q == ST_FILL_REQ);
  assign rd_req_line  = r_line;
endmodule

// File: rtl/wb_cache2w_chk.sv
module wb_cache2w_chk #(
  parameter int LA_W   = 4,
  parameter int LINE_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              resp_valid,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [LA_W-1:0]   rd_req_line,
  input logic              wb_valid,
  input logic              wb_ready,
  input logic [LA_W-1:0]   wb_line,
  input logic [LINE_W-1:0] wb_data,
  input logic              q_push,
  input logic              q_full,
  input logic              q_probe_hit
);
  AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid); // R4

  AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R13

  AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !rd_req_valid); // R13

  AST_READ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_line))); // R13

  AST_WB_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_line) && $stable(wb_data))); // R10

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    q_push |-> !q_full); // R11

  AST_NO_STALE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> !q_probe_hit); // R12
endmodule

bind wb_cache2w wb_cache2w_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .resp_valid  (resp_valid),
  .rd_req_valid(rd_req_valid),
  .rd_req_ready(rd_req_ready),
  .rd_req_line (rd_req_line),
  .wb_valid    (wb_valid),
  .wb_ready    (wb_ready),
  .wb_line     (wb_line),
  .wb_data     (wb_data),
  .q_push      (q_push),
  .q_full      (q_full),
  .q_probe_hit (q_probe_hit)
);

// File: tb/wb_cache2w_bench.sv
`timescale 1ns/1ps
module wb_cache2w_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [4:0]  req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        resp_valid;
  logic [7:0]  resp_rdata;
  logic        rd_req_valid;
  logic        rd_req_ready;
  logic [3:0]  rd_req_line;
  logic        rd_resp_valid;
  logic [15:0] rd_resp_data;
  logic        wb_valid;
  logic        wb_ready;
  logic [3:0]  wb_line;
  logic [15:0] wb_data;
  logic        wb_done;

  always #10 clk = ~clk;

  wb_cache2w u_wb_cache2w (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_line(rd_req_line),
    .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_line(wb_line), .wb_data(wb_data),
    .wb_done(wb_done)
  );

  int          tests = 0;
  int          fails = 0;
  bit          finished = 1'b0;
  bit          wb_hold = 1'b0;
  int          rd_cnt = 0;
  int          wb_cnt = 0;
  logic [3:0]  last_rd_line = '0;
  logic [15:0] mem_line [16];
  logic [7:0]  ref_b [32];
  logic [3:0]  wb_log_line [256];
  logic [15:0] wb_log_data [256];

  function automatic logic [7:0] init_b(input int a);
    return 8'((a * 37 + 27) & 255);
  endfunction

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  // memory read side
  initial begin
    rd_req_ready  = 1'b0;
    rd_resp_valid = 1'b0;
    rd_resp_data  = '0;
    forever begin
      @(negedge clk);
      rd_resp_valid = 1'b0;
      if (rd_req_valid) begin
        logic [3:0] ln;
        repeat ($urandom_range(0, 2)) @(negedge clk);
        rd_req_ready = 1'b1;
        ln = rd_req_line;
        @(negedge clk);
        rd_req_ready = 1'b0;
        rd_cnt++;
        last_rd_line = ln;
        repeat ($urandom_range(0, 3)) @(negedge clk);
        rd_resp_valid = 1'b1;
        rd_resp_data  = mem_line[ln];
      end
    end
  end

  // memory writeback side
  initial begin
    wb_ready = 1'b0;
    wb_done  = 1'b0;
    forever begin
      @(negedge clk);
      wb_done = 1'b0;
      if (wb_valid && !wb_hold) begin
        logic [3:0]  ln;
        logic [15:0] dt;
        repeat ($urandom_range(0, 2)) @(negedge clk);
        wb_ready = 1'b1;
        ln = wb_line;
        dt = wb_data;
        @(negedge clk);
        wb_ready = 1'b0;
        repeat ($urandom_range(1, 6)) @(negedge clk);
        mem_line[ln] = dt;
        if (wb_cnt < 256) begin
          wb_log_line[wb_cnt] = ln;
          wb_log_data[wb_cnt] = dt;
        end
        wb_cnt++;
        wb_done = 1'b1;
      end
    end
  end

  task automatic start_req(input bit we, input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_write = we;
    req_addr  = a;
    req_wdata = d;
    if (we) ref_b[a] = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_resp(output logic [7:0] rd, output int lat, input int lat0);
    lat = lat0;
    while (!resp_valid) begin
      @(negedge clk);
      lat++;
    end
    rd = resp_rdata;
  endtask

  task automatic access(input bit we, input logic [4:0] a, input logic [7:0] d,
                        output logic [7:0] rd, output int lat);
    start_req(we, a, d);
    wait_resp(rd, lat, 1);
  endtask

  task automatic load_chk(input string req, input logic [4:0] a);
    logic [7:0] rd;
    int lat;
    access(1'b0, a, 8'h00, rd, lat);
    check_eq(req, $sformatf("load data @%0d", a), rd, ref_b[a]);
  endtask

  initial begin
    logic [7:0] rd;
    int lat, rc0, wc0, seen;
    void'($urandom(32'h0C0F_FEE1));
    for (int l = 0; l < 16; l++) mem_line[l] = {init_b(2 * l + 1), init_b(2 * l)};
    for (int a = 0; a < 32; a++) ref_b[a] = init_b(a);

    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    check_eq("R1", "req_ready", req_ready, 1);
    check_eq("R1", "resp_valid", resp_valid, 0);
    check_eq("R1", "rd_req_valid", rd_req_valid, 0);
    check_eq("R1", "wb_valid", wb_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5/R2: first access misses and reads line 0
    rc0 = rd_cnt;
    access(1'b0, 5'd0, 8'h00, rd, lat);
    check_eq("R5", "refill count", rd_cnt - rc0, 1);
    check_eq("R2", "refill line", last_rd_line, 0);
    check_eq("R3", "load 0", rd, ref_b[0]);
    check_eq("R4", "miss slower than hit", int'(lat > 2), 1);

    // R4: same line hits in two edges, no memory traffic
    rc0 = rd_cnt;
    access(1'b0, 5'd1, 8'h00, rd, lat);
    check_eq("R4", "hit latency", lat, 2);
    check_eq("R4", "hit reads", rd_cnt - rc0, 0);
    check_eq("R3", "load 1", rd, ref_b[1]);

    // store miss allocates line 4 into the other way
    rc0 = rd_cnt;
    access(1'b1, 5'd8, 8'hA5, rd, lat);
    check_eq("R5", "store-miss refill", rd_cnt - rc0, 1);
    check_eq("R2", "store refill line", last_rd_line, 4);

    access(1'b0, 5'd0, 8'h00, rd, lat);         // way0 now most recent
    check_eq("R8", "hit on line 0", lat, 2);

    // R9: dirty victim held in queue, refill still completes
    wb_hold = 1'b1;
    wc0 = wb_cnt;
    access(1'b0, 5'd16, 8'h00, rd, lat);
    check_eq("R9", "load 16 with wb pending", rd, ref_b[16]);
    check_eq("R9", "wb not yet confirmed", wb_cnt - wc0, 0);
    check_eq("R9", "wb offered", wb_valid, 1);

    // R8: line 0 survived, the way holding line 4 was replaced
    access(1'b0, 5'd0, 8'h00, rd, lat);
    check_eq("R8", "line 0 still hits", lat, 2);

    // R12: miss to the queued line waits for confirmation
    rc0 = rd_cnt;
    seen = 0;
    start_req(1'b0, 5'd8, 8'h00);
    repeat (20) begin
      if (resp_valid) seen++;
      @(negedge clk);
    end
    check_eq("R12", "no refill while queued", rd_cnt - rc0, 0);
    check_eq("R12", "no response while queued", seen, 0);
    wb_hold = 1'b0;
    wait_resp(rd, lat, 0);
    check_eq("R12", "load 8 returns stored byte", rd, 8'hA5);
    check_eq("R7", "one writeback", wb_cnt - wc0, 1);
    check_eq("R7", "wb line", wb_log_line[wc0], 4);
    check_eq("R7", "wb data", wb_log_data[wc0], {init_b(9), 8'hA5});
    check_eq("R5", "refill after drain", last_rd_line, 4);
    repeat (20) @(negedge clk);
    check_eq("R7", "clean eviction silent", wb_cnt - wc0, 1);

    // R6: store hit only touches the cache
    rc0 = rd_cnt;
    wc0 = wb_cnt;
    access(1'b1, 5'd0, 8'h3C, rd, lat);
    check_eq("R6", "store hit latency", lat, 2);
    repeat (20) @(negedge clk);
    check_eq("R6", "no writeback", wb_cnt - wc0, 0);
    check_eq("R6", "no refill", rd_cnt - rc0, 0);
    load_chk("R6", 5'd0);
    load_chk("R3", 5'd1);

    // R11/R10: fill the queue in set 1 and stall the next dirty eviction
    wb_hold = 1'b1;
    wc0 = wb_cnt;
    access(1'b1, 5'd2,  8'h11, rd, lat);
    access(1'b1, 5'd10, 8'h22, rd, lat);
    check_eq("R2", "set 1 tag 1 line", last_rd_line, 5);
    access(1'b1, 5'd18, 8'h33, rd, lat);
    access(1'b1, 5'd26, 8'h44, rd, lat);
    rc0 = rd_cnt;
    seen = 0;
    start_req(1'b1, 5'd2, 8'h55);
    repeat (15) begin
      if (resp_valid) seen++;
      @(negedge clk);
    end
    check_eq("R11", "no response when full", seen, 0);
    check_eq("R11", "stall visible", req_ready, 0);
    check_eq("R11", "no refill when full", rd_cnt - rc0, 0);
    wb_hold = 1'b0;
    wait_resp(rd, lat, 0);
    check_eq("R11", "store echoes byte", rd, 8'h55);
    repeat (60) @(negedge clk);
    check_eq("R10", "three writebacks", wb_cnt - wc0, 3);
    check_eq("R10", "first line", wb_log_line[wc0], 1);
    check_eq("R10", "second line", wb_log_line[wc0 + 1], 5);
    check_eq("R10", "third line", wb_log_line[wc0 + 2], 9);
    check_eq("R7", "first data", wb_log_data[wc0], {init_b(3), 8'h11});
    check_eq("R7", "third data", wb_log_data[wc0 + 2], {init_b(19), 8'h33});
    load_chk("R3", 5'd10);
    load_chk("R3", 5'd18);
    load_chk("R3", 5'd26);
    load_chk("R3", 5'd2);

    // random traffic against the byte reference
    for (int n = 0; n < 400; n++) begin
      logic [4:0] a;
      bit we;
      a  = 5'($urandom_range(0, 31));
      we = 1'($urandom_range(0, 1));
      access(we, a, 8'($urandom), rd, lat);
      if (!we) check_eq("R3", $sformatf("random load @%0d", a), rd, ref_b[a]);
    end
    for (int a = 0; a < 32; a++) load_chk("R3", 5'(a));
    repeat (50) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule